// File: doc/BRIEF.md
# Memory-mapped level interrupt controller

This block gathers up to 32 interrupt lines into one interrupt request for a CPU. Software sees it through a simple register bus. A cause register shows the state of each line and a mask register enables each line. The request output is high while any enabled line has its cause bit set. Almost every line is level-sensitive and passes straight through, so its cause bit follows its source. One line belongs to a reset push-button. That line is captured on the press edge and stays set until software acknowledges it by writing a 1 to its bit in the cause register.

The cause register also carries the live state of the button as an active-low status bit. A third register returns the lowest-numbered pending, enabled line, so a handler can dispatch without scanning. Any write to the platform-reset register starts a fixed-length reset pulse.

Register offsets: cause 0x00, mask 0x04, pending index 0x08, platform reset 0x24. Reads are combinational from `addr_i`. A write takes effect at the clock edge on which `req_i` and `we_i` are both high.

Top module: `level_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0, `irq_o` and `plat_rst_o` are low, the button cause bit (line 1 by default) reads 0, and cause bit 16 reads 1 while the button is released.
- R2: For every line other than the button line and bit 16, cause bit i reads `src_i[i]` in the same cycle. Writing 1s to those bits of the cause register has no lasting effect on them.
- R3: The mask register at 0x04 holds the written value. `irq_o` is high exactly when some line has both its cause bit and its mask bit at 1 (1 = enabled), with bit 16 excluded.
- R4: The button cause bit is set on the press edge (a fall of `rsw_ni`). It reads 1 three clock edges after the fall and stays set while no acknowledge arrives. Holding the button does not set it again after an acknowledge.
- R5: Writing the cause register with a 1 in the button bit position clears that bit. Writing 0 there leaves it set.
- R6: Cause bit 16 reads the synchronized button state: 0 from two edges after `rsw_ni` falls, and 1 when released. `src_i[16]` is ignored and bit 16 never raises `irq_o`.
- R7: Writing 0x00000000 to the mask register and 0xFFFFFFFF to the cause register leaves `irq_o` low, the mask at 0, and the button cause bit clear.
- R8: Any write to 0x24, whatever the data, drives `plat_rst_o` high for exactly RST_LEN cycles (default 16), starting at the edge of the write.
- R9: A read of 0x08 returns the index of the lowest-numbered pending enabled line in bits [4:0], with the other bits 0. When no line is pending it returns 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| src_i | input | 32 | Level interrupt sources, active high |
| rsw_ni | input | 1 | Raw reset push-button, low while pressed |
| irq_o | output | 1 | Combined interrupt request |
| plat_rst_o | output | 1 | Platform reset pulse |

## Verification
Level lines, the pending index and `irq_o` respond in the same cycle, so the bench changes `src_i` on a falling edge and samples one time step later. Register writes land on the next rising edge and are read back on the falling edge after it. The button status is checked two edges after the fall of `rsw_ni`, and the latched cause bit three edges after, with a check one edge earlier that it is not yet set. The reset pulse is counted on falling edges over a window longer than RST_LEN, starting after the write edge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_FIND  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PRST  = 8'h24;
endpackage

// File: rtl/rsw_latch.sv
module rsw_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rsw_ni,
  input  logic ack_i,
  output logic state_o,
  output logic pend_o
);
  logic s1_q, s2_q, s3_q, pend_q;
  logic press;

  assign press = s3_q & ~s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      s3_q   <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      s1_q <= rsw_ni;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (press)      pend_q <= 1'b1;  // a new press wins over an acknowledge
      else if (ack_i) pend_q <= 1'b0;
    end
  end

  assign state_o = s2_q;
  assign pend_o  = pend_q;

  a_r4_set_on_press: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press |=> pend_o);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !ack_i |=> pend_o);
  a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !press |=> !pend_o);
endmodule

// File: rtl/low_index_find.sv
module low_index_find #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;

  always_comb begin
    if (any_o) a_r9_hit_set: assert (vec_i[idx_o]);
  end
endmodule

// File: rtl/rst_pulse.sv
module rst_pulse #(
  parameter int RST_LEN = 16,
  localparam int CW = $clog2(RST_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(RST_LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  a_r8_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pulse_o);
  a_r8_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && cnt_q == CW'(1) |=> !pulse_o);
endmodule

// File: rtl/level_irq_ctrl.sv
module level_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int RSW_IDX   = 1,
  parameter int STAT_BIT  = 16,
  parameter int RST_LEN   = 16,
  localparam int IW = $clog2(NUM_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_LINES-1:0] src_i,
  input  logic              rsw_ni,
  output logic              irq_o,
  output logic              plat_rst_o
);
  logic [NUM_LINES-1:0] mask_q, cause, irq_src, pend;
  logic wr, wr_cause, wr_mask, wr_prst;
  logic rsw_state, rsw_pend, find_any;
  logic [IW-1:0] find_idx;
  logic unused_src;

  assign wr       = req_i & we_i;
  assign wr_cause = wr & (addr_i == OFS_CAUSE);
  assign wr_mask  = wr & (addr_i == OFS_MASK);
  assign wr_prst  = wr & (addr_i == OFS_PRST);
  assign unused_src = src_i[RSW_IDX] ^ src_i[STAT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (wr_mask) mask_q <= wdata_i[NUM_LINES-1:0];
  end

  rsw_latch u_rsw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rsw_ni  (rsw_ni),
    .ack_i   (wr_cause & wdata_i[RSW_IDX]),
    .state_o (rsw_state),
    .pend_o  (rsw_pend)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i == RSW_IDX) begin : g_rsw
      assign cause[i]   = rsw_pend;
      assign irq_src[i] = rsw_pend;
    end else if (i == STAT_BIT) begin : g_stat
      assign cause[i]   = rsw_state;
      assign irq_src[i] = 1'b0;
    end else begin : g_lvl
      assign cause[i]   = src_i[i];
      assign irq_src[i] = src_i[i];
    end
  end

  assign pend  = irq_src & mask_q;
  assign irq_o = |pend;

  low_index_find #(.N(NUM_LINES)) u_find (
    .vec_i (pend),
    .any_o (find_any),
    .idx_o (find_idx)
  );

  rst_pulse #(.RST_LEN(RST_LEN)) u_prst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_prst),
    .pulse_o (plat_rst_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CAUSE: rdata_o[NUM_LINES-1:0] = cause;
      OFS_MASK:  rdata_o[NUM_LINES-1:0] = mask_q;
      OFS_FIND: begin
        rdata_o[IW-1:0]     = find_any ? find_idx : '0;
        rdata_o[DATA_W-1]   = ~find_any;
      end
      default:   rdata_o = '0;
    endcase
  end

  a_r3_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q == '0 |-> !irq_o);
  a_r3_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> mask_q == $past(wdata_i[NUM_LINES-1:0]));
  a_r6_stat_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q & ~(NUM_LINES'(1) << STAT_BIT)) == '0 |-> !irq_o);
endmodule

// File: tb/sim_level_irq_ctrl.sv
module sim_level_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RST_LEN = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata, src = '0;
  logic rsw_n = 1'b1, irq, prst;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  level_irq_ctrl #(.RST_LEN(RST_LEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .rsw_ni(rsw_n),
    .irq_o(irq), .plat_rst_o(prst));

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 plat_rst", {31'b0, prst}, 32'h0);
    rd(8'h04, d); chk("R1 mask", d, 32'h0);
    rd(8'h00, d); chk("R1 cause", d, 32'h0001_0000);
    rd(8'h08, d); chk("R9 none pending", d, 32'h8000_0000);
  endtask

  task automatic t_level;
    logic [31:0] d;
    @(negedge clk); src = 32'h0000_0020;
    #1 chk("R3 masked line quiet", {31'b0, irq}, 32'h0);
    rd(8'h00, d); chk("R2 pass-through", d & 32'h0000_0020, 32'h0000_0020);
    wr(8'h04, 32'h0000_0020);
    #1 chk("R3 enabled line irq", {31'b0, irq}, 32'h1);
    rd(8'h04, d); chk("R3 mask readback", d, 32'h0000_0020);
    rd(8'h08, d); chk("R9 index 5", d, 32'd5);
    src = 32'h0;
    #1 chk("R2 source drop clears irq", {31'b0, irq}, 32'h0);
    wr(8'h04, 32'hFFFF_FFFF);
    src = 32'h0010_0008;
    rd(8'h08, d); chk("R9 lowest of two", d, 32'd3);
    src = 32'h0;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R2 write ones no effect", d & ~32'h0001_0002, 32'h0);
    src = 32'h0001_0000;
    #1 chk("R6 src16 ignored", {31'b0, irq}, 32'h0);
    rd(8'h08, d); chk("R6 src16 not pending", d, 32'h8000_0000);
    src = 32'h0;
  endtask

  task automatic t_switch;
    logic [31:0] d;
    @(negedge clk); rsw_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd(8'h00, d);
    chk("R6 status low while held", d & 32'h0001_0000, 32'h0);
    chk("R4 not yet latched", d & 32'h2, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(8'h00, d); chk("R4 latched on press", d & 32'h2, 32'h2);
    rd(8'h08, d); chk("R4 pending index", d, 32'd1);
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R5 zero write keeps", d & 32'h2, 32'h2);
    wr(8'h00, 32'h2);
    rd(8'h00, d); chk("R5 ack clears", d & 32'h2, 32'h0);
    repeat (5) @(negedge clk);
    rd(8'h00, d); chk("R4 held no re-latch", d & 32'h2, 32'h0);
    chk("R4 irq low after ack", {31'b0, irq}, 32'h0);
    rsw_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(8'h00, d); chk("R6 status high released", d & 32'h0001_0000, 32'h0001_0000);
    rsw_n = 1'b0;
    repeat (4) @(negedge clk);
    rsw_n = 1'b1;
    #1 chk("R4 second press irq", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R7 quiesce cause", d & 32'h2, 32'h0);
    rd(8'h04, d); chk("R7 quiesce mask", d, 32'h0);
    chk("R7 quiesce irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_prst;
    int n = 0;
    wr(8'h24, 32'h0);
    n = prst ? 1 : 0;
    for (int k = 0; k < RST_LEN + 4; k++) begin
      @(negedge clk);
      if (prst) n++;
    end
    chk("R8 pulse length", n, RST_LEN);
    chk("R8 pulse ended", {31'b0, prst}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_level();
    t_switch();
    t_prst();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule